// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block sits in front of a small word-addressed storage array at a memory target. Each request names one word and carries a 6-bit atomic opcode plus one or two data operands. In a single clock edge the block reads the addressed word, works out the replacement value, writes it back and captures the response. No other request can reach the array between the read and the write, so every operation is indivisible.

The opcode picks one of four atomic classes, a plain write, or a reserved code. The classes are store, load, swap and compare-and-swap. Store and load each apply one of eight arithmetic or logical operations. A store answers without data. Load, swap and compare-and-swap return the value the word held before the request. A reserved code is refused with an error and leaves the array alone.

Requests and responses use valid/ready handshakes. At most one transaction is outstanding, and a new request is accepted only after the previous response has been taken.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and every storage word reads as zero.
- R2: Opcode 6'b000000 (plain write) stores `req_operand` into the addressed word. Its response has `rsp_err`=0, `rsp_has_data`=0 and `rsp_rdata`=0.
- R3: Opcode bits [5:4]=01 is a store. Bits [2:0] select the new value from the old word O and operand D: 0 O+D, 1 O&~D, 2 O^D, 3 O|D, 4 signed max, 5 signed min, 6 unsigned max, 7 unsigned min. The response carries no data (`rsp_has_data`=0, `rsp_rdata`=0).
- R4: Opcode bits [5:4]=10 is a load. It applies the same eight operations as R3 and returns the old word O with `rsp_has_data`=1.
- R5: Opcode 6'b110000 (swap) writes `req_operand` unconditionally and returns the old word with `rsp_has_data`=1.
- R6: Opcode 6'b110001 (compare-and-swap) writes `req_operand` only when the old word equals `req_compare`. Otherwise the word is unchanged. In both cases the old word is returned with `rsp_has_data`=1.
- R7: For store and load, opcode bit 3 is ignored. An opcode with bit 3 set behaves exactly like the same opcode with bit 3 clear.
- R8: Reserved opcodes are 00 with bits [3:0] nonzero, and 11 with bits [3:0] above 0001. They give `rsp_err`=1, `rsp_has_data`=0 and `rsp_rdata`=0, and leave the storage unchanged.
- R9: From acceptance until the response handshake, `req_ready` stays 0 and the response fields hold steady while `rsp_ready` is 0.
- R10: `rsp_valid` rises in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_opc | input | 6 | Atomic opcode |
| req_addr | input | ADDR_W | Word address |
| req_operand | input | DATA_W | Operand, swap value or plain-write data |
| req_compare | input | DATA_W | Compare value for compare-and-swap |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Request used a reserved opcode |
| rsp_has_data | output | 1 | Response carries the old word |
| rsp_rdata | output | DATA_W | Old word, or zero for responses without data |

## Verification
Two things can happen in the same cycle: a response still waiting to be taken, and a new request already being driven. The bench provokes this by holding `req_valid` high, with the next request's fields, through random response stalls. It then checks that `req_ready` stays low and the response stays unchanged during the stall, and that the waiting request is carried out exactly once, right after the handshake. Compare-and-swap operands are biased so that the stored value matches about half the time. Signed and unsigned extremes exercise the min and max operations.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
   localparam int OPC_W = 6;

   typedef enum logic [2:0] {
      K_WRITE, K_STORE, K_LOAD, K_SWAP, K_CMP, K_BAD
   } kind_e;

   typedef enum logic [2:0] {
      OP_ADD, OP_BIC, OP_XOR, OP_BIS, OP_SMAX, OP_SMIN, OP_UMAX, OP_UMIN
   } op_e;
endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
   import atomic_rmw_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output kind_e            kind,
   output op_e              op
);
   // bit 3 is never looked at for store/load (R7)
   always_comb begin
      op = op_e'(opc[2:0]);
      unique case (opc[5:4])
         2'b00:   kind = (opc[3:0] == 4'h0) ? K_WRITE : K_BAD;
         2'b01:   kind = K_STORE;
         2'b10:   kind = K_LOAD;
         default: begin
            if (opc[3:0] == 4'h0)      kind = K_SWAP;
            else if (opc[3:0] == 4'h1) kind = K_CMP;
            else                       kind = K_BAD;
         end
      endcase
   end
endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
   import atomic_rmw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  kind_e             kind,
   input  op_e               op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] compare,
   output logic [DATA_W-1:0] new_val,
   output logic              wr,
   output logic              ret_old,
   output logic              err
);
   function automatic logic [DATA_W-1:0] apply_op(op_e o, logic [DATA_W-1:0] a,
                                                  logic [DATA_W-1:0] b);
      logic [DATA_W-1:0] r;
      unique case (o)
         OP_ADD:  r = a + b;
         OP_BIC:  r = a & ~b;
         OP_XOR:  r = a ^ b;
         OP_BIS:  r = a | b;
         OP_SMAX: r = ($signed(a) > $signed(b)) ? a : b;
         OP_SMIN: r = ($signed(a) < $signed(b)) ? a : b;
         OP_UMAX: r = (a > b) ? a : b;
         default: r = (a < b) ? a : b;
      endcase
      return r;
   endfunction

   always_comb begin
      new_val = old_val;
      wr      = 1'b0;
      ret_old = 1'b0;
      err     = 1'b0;
      unique case (kind)
         K_WRITE: begin new_val = operand; wr = 1'b1; end
         K_STORE: begin new_val = apply_op(op, old_val, operand); wr = 1'b1; end
         K_LOAD:  begin new_val = apply_op(op, old_val, operand); wr = 1'b1; ret_old = 1'b1; end
         K_SWAP:  begin new_val = operand; wr = 1'b1; ret_old = 1'b1; end
         K_CMP:   begin
            ret_old = 1'b1;
            wr      = (old_val == compare);
            if (wr) new_val = operand;
         end
         default: err = 1'b1;
      endcase
   end
endmodule

// File: rtl/atomic_rmw_mem.sv
module atomic_rmw_mem #(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 16,
   parameter bit RESET_ROWS = 1'b1,
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rd_arr [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      logic [DATA_W-1:0] row_q;
      if (RESET_ROWS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          row_q <= '0;
            else if (we && waddr == ADDR_W'(g))  row_q <= wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && waddr == ADDR_W'(g)) row_q <= wdata;
         end
      end
      assign rd_arr[g] = row_q;
   end

   assign rdata = rd_arr[raddr];

   // a write is visible at its address on the next cycle (R2)
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rd_arr[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              rsp_ready,
   output logic              rsp_valid,
   input  logic              alu_wr,
   input  logic              alu_ret_old,
   input  logic              alu_err,
   input  logic [DATA_W-1:0] old_val,
   output logic              mem_we,
   output logic              rsp_err,
   output logic              rsp_has_data,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic busy_q;
   logic accept;

   assign req_ready = !busy_q;
   assign accept    = req_valid && !busy_q;
   assign mem_we    = accept && alu_wr;
   assign rsp_valid = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         rsp_err      <= 1'b0;
         rsp_has_data <= 1'b0;
         rsp_rdata    <= '0;
      end else if (accept) begin
         busy_q       <= 1'b1;
         rsp_err      <= alu_err;
         rsp_has_data <= alu_ret_old && !alu_err;
         rsp_rdata    <= (alu_ret_old && !alu_err) ? old_val : '0;
      end else if (busy_q && rsp_ready) begin
         busy_q <= 1'b0;
      end
   end

   assert_rsp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid);
   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)
                                  && $stable(rsp_err) && $stable(rsp_has_data));
   assert_err_nodata_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> !rsp_has_data && rsp_rdata == '0);
   assert_bad_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alu_err |-> !mem_we);
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import atomic_rmw_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 16,
   parameter bit RESET_ROWS = 1'b1,
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [5:0]        req_opc,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_operand,
   input  logic [DATA_W-1:0] req_compare,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_err,
   output logic              rsp_has_data,
   output logic [DATA_W-1:0] rsp_rdata
);
   if (DATA_W < 8)             $error("DATA_W must be at least 8");
   if (DEPTH < 2)              $error("DEPTH must be at least 2");
   if ((1 << ADDR_W) != DEPTH) $error("DEPTH must be a power of two");

   kind_e             kind;
   op_e               op;
   logic [DATA_W-1:0] old_val, new_val;
   logic              alu_wr, alu_ret_old, alu_err, mem_we;

   atomic_rmw_decode u_dec (.opc(req_opc), .kind(kind), .op(op));

   atomic_rmw_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RESET_ROWS(RESET_ROWS)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(req_addr), .wdata(new_val),
      .raddr(req_addr), .rdata(old_val));

   atomic_rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .kind(kind), .op(op), .old_val(old_val), .operand(req_operand),
      .compare(req_compare), .new_val(new_val), .wr(alu_wr),
      .ret_old(alu_ret_old), .err(alu_err));

   atomic_rmw_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .alu_wr(alu_wr),
      .alu_ret_old(alu_ret_old), .alu_err(alu_err), .old_val(old_val),
      .mem_we(mem_we), .rsp_err(rsp_err), .rsp_has_data(rsp_has_data),
      .rsp_rdata(rsp_rdata));
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
   localparam int DW = 32;
   localparam int DEPTH = 16;
   localparam int AW = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, rsp_ready = 1'b0;
   logic [5:0] req_opc = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_operand = '0, req_compare = '0;
   logic req_ready, rsp_valid, rsp_err, rsp_has_data;
   logic [DW-1:0] rsp_rdata;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] model [DEPTH];

   always #5 clk = ~clk;

   atomic_rmw_unit #(.DATA_W(DW), .DEPTH(DEPTH)) u_atomic_rmw_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_opc(req_opc), .req_addr(req_addr), .req_operand(req_operand),
      .req_compare(req_compare), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_err(rsp_err), .rsp_has_data(rsp_has_data), .rsp_rdata(rsp_rdata));

   task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] op_ref(logic [2:0] o, logic [DW-1:0] a, logic [DW-1:0] b);
      case (o)
         3'd0: return a + b;
         3'd1: return a & ~b;
         3'd2: return a ^ b;
         3'd3: return a | b;
         3'd4: return ($signed(a) >= $signed(b)) ? a : b;
         3'd5: return ($signed(a) <= $signed(b)) ? a : b;
         3'd6: return (a >= b) ? a : b;
         default: return (a <= b) ? a : b;
      endcase
   endfunction

   task automatic run_req(logic [5:0] opc, int addr, logic [DW-1:0] opnd,
                          logic [DW-1:0] cmpv, int stall, bit hold, string tag);
      logic [DW-1:0] old, nv, exp_d;
      bit err, hasd;
      string t;
      old = model[addr]; nv = old; err = 0; hasd = 0; t = tag;
      case (opc[5:4])
         2'b00: begin if (opc[3:0] == 0) nv = opnd; else err = 1; if (t == "") t = err ? "R8" : "R2"; end
         2'b01: begin nv = op_ref(opc[2:0], old, opnd); if (t == "") t = "R3"; end
         2'b10: begin nv = op_ref(opc[2:0], old, opnd); hasd = 1; if (t == "") t = "R4"; end
         default: begin
            if (opc[3:0] == 0) begin nv = opnd; hasd = 1; if (t == "") t = "R5"; end
            else if (opc[3:0] == 1) begin nv = (old == cmpv) ? opnd : old; hasd = 1; if (t == "") t = "R6"; end
            else begin err = 1; if (t == "") t = "R8"; end
         end
      endcase
      exp_d = hasd ? old : '0;
      req_opc = opc; req_addr = AW'(addr); req_operand = opnd; req_compare = cmpv;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      if (!hold) req_valid = 1'b0;
      model[addr] = nv;
      chk(rsp_valid === 1'b1, "R10 rsp_valid", DW'(rsp_valid), 1);
      chk(req_ready === 1'b0, "R9 req_ready busy", DW'(req_ready), 0);
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         chk(rsp_valid === 1'b1 && rsp_rdata === exp_d, "R9 hold", rsp_rdata, exp_d);
         chk(req_ready === 1'b0, "R9 no accept while pending", DW'(req_ready), 0);
      end
      chk(rsp_err === err, {t, " rsp_err"}, DW'(rsp_err), DW'(err));
      chk(rsp_has_data === hasd, {t, " rsp_has_data"}, DW'(rsp_has_data), DW'(hasd));
      chk(rsp_rdata === exp_d, {t, " rsp_rdata"}, rsp_rdata, exp_d);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(rsp_valid === 1'b0, "R9 rsp taken", DW'(rsp_valid), 0);
      if (!hold) chk(req_ready === 1'b1, "R9 ready again", DW'(req_ready), 1);
   endtask

   // read through load-add-zero, which leaves the word unchanged
   task automatic peek(int addr, string tag);
      run_req(6'b100000, addr, '0, '0, 0, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [5:0] opc;
      logic [DW-1:0] a, b;
      int ad;
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R1 req_ready", DW'(req_ready), 1);
      chk(rsp_valid === 1'b0, "R1 rsp_valid", DW'(rsp_valid), 0);
      for (int i = 0; i < DEPTH; i++) peek(i, "R1");

      run_req(6'b000000, 3, 32'hA5A5_0F0F, '0, 1, 0, "R2");
      peek(3, "R2");
      // all eight operations with signed/unsigned extremes
      for (int o = 0; o < 8; o++) begin
         run_req(6'b000000, 5, 32'h8000_0001, '0, 0, 0, "");
         run_req({3'b010, 3'(o)}, 5, 32'h7FFF_FFFF, '0, 0, 0, "R3");
         peek(5, "R3");
         run_req(6'b000000, 6, 32'h0000_00F0, '0, 0, 0, "");
         run_req({3'b100, 3'(o)}, 6, 32'hFFFF_FF0F, '0, 1, 0, "R4");
         peek(6, "R4");
      end
      run_req(6'b011010, 6, 32'h1234_5678, '0, 0, 0, "R7");
      peek(6, "R7");
      run_req(6'b101000, 6, 32'h0000_0001, '0, 0, 0, "R7");
      peek(6, "R7");
      run_req(6'b110000, 7, 32'hDEAD_BEEF, '0, 0, 0, "R5");
      peek(7, "R5");
      run_req(6'b110001, 7, 32'h1111_1111, 32'hDEAD_BEEF, 0, 0, "R6");
      peek(7, "R6");
      run_req(6'b110001, 7, 32'h2222_2222, 32'hDEAD_BEEF, 0, 0, "R6");
      peek(7, "R6");
      run_req(6'b000101, 7, 32'hFFFF_FFFF, '0, 0, 0, "R8");
      run_req(6'b110010, 7, 32'hFFFF_FFFF, '0, 0, 0, "R8");
      run_req(6'b111111, 7, 32'hFFFF_FFFF, '0, 2, 0, "R8");
      peek(7, "R8");
      // request held during a stalled response; executed once, after handoff
      run_req(6'b010000, 2, 32'h0000_0010, '0, 3, 1, "R9");
      run_req(6'b010000, 2, 32'h0000_0010, '0, 0, 0, "R9");
      peek(2, "R9");

      for (int n = 0; n < 300; n++) begin
         ad = $urandom % DEPTH;
         a = $urandom;
         b = ($urandom % 2) ? model[ad] : $urandom;
         case ($urandom % 10)
            0: opc = 6'b000000;
            1, 2, 3: opc = {2'b01, 1'($urandom), 3'($urandom)};
            4, 5, 6: opc = {2'b10, 1'($urandom), 3'($urandom)};
            7: opc = 6'b110000;
            8: opc = 6'b110001;
            default: opc = ($urandom % 2) ? {2'b00, 4'(1 + $urandom % 15)}
                                          : {2'b11, 4'(2 + $urandom % 14)};
         endcase
         run_req(opc, ad, a, b, $urandom % 4, ($urandom % 8) == 0, "");
      end
      for (int i = 0; i < DEPTH; i++) peek(i, "");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule